// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits behind a receive frame parser and decides, for each frame, whether the frame is kept or dropped. The decision rests on the 48-bit destination address. The parser presents the address, the length/type field and the payload byte count it actually counted, together with a one-cycle frame strobe. One clock later the block returns an accept flag and a 3-bit code that says which rule let the frame through, or that no rule did.

Four static mode inputs select the rules. Promiscuous mode keeps every frame. The broadcast gate controls the all-ones address. The multicast gate lets group-addressed frames through when they hit a 64-bit hash table. Length checking drops frames whose length field disagrees with the counted payload. A single configuration write port loads and invalidates four exact-match address slots. The same port sets, deletes or clears entries in the hash table.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: The decision appears exactly one clock after a frame strobe. `dec_valid` is high for that one cycle only. `dec_accept` is 0 whenever `dec_valid` is 0. After reset, `dec_valid` and `dec_accept` are 0 and `dec_code` is 7.
- R2: Opcode 0 writes `cfg_data` into slot `cfg_slot` and marks the slot valid. Opcode 1 marks the slot invalid. A valid slot whose address equals the destination address accepts the frame with code equal to the slot number (0 to 3). An invalid slot never matches.
- R3: When several slots match, the lowest slot number is reported. A slot match takes precedence over the broadcast, hash and promiscuous codes.
- R4: The all-ones destination address is accepted with code 4 only when `bcast_en` is 1. The all-ones address is never tested against the hash table.
- R5: A group address is one with `dst_addr[40]` set, which is bit 0 of the first octet, carried in `dst_addr[47:40]`. A group address other than all-ones is accepted with code 5 when `mcast_en` is 1 and the hash bit it selects is set. An individual address (`dst_addr[40]` = 0) never produces code 5.
- R6: The hash index is the XOR of the eight 6-bit fields `dst_addr[6k+5:6k]`, for k = 0 to 7. Opcodes 2 and 3 apply the same fold to `cfg_data`.
- R7: Opcode 2 sets the hash bit selected by `cfg_data`. Opcode 3 clears only that bit. Opcode 4 clears the whole table. Opcodes 5 to 7 change nothing.
- R8: With `promisc_en` set, every frame is accepted. A frame that no higher rule matched gets code 6.
- R9: Length checking applies when `lencheck_en` is 1 and `len_type` is below 0x0600. In that case, if `len_type` differs from `pay_len`, the frame is rejected with code 7 unless `promisc_en` is set, which gives code 6. Values of 0x0600 and above are types and are never checked.
- R10: Code 7 means rejected, and `dec_accept` is 1 exactly when the code is not 7.
- R11: A frame strobe in the same cycle as a configuration write is judged against the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle frame strobe from the parser |
| dst_addr | input | 48 | Destination address; first octet in [47:40] |
| len_type | input | 16 | Length/type field of the frame |
| pay_len | input | 16 | Payload byte count measured by the parser |
| promisc_en | input | 1 | Accept every frame |
| bcast_en | input | 1 | Accept the all-ones address |
| mcast_en | input | 1 | Accept group addresses that hit the hash table |
| lencheck_en | input | 1 | Drop frames whose length field mismatches |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | 0 load slot, 1 invalidate slot, 2 hash set, 3 hash delete, 4 hash clear |
| cfg_slot | input | 2 | Slot number for opcodes 0 and 1 |
| cfg_data | input | 48 | Address for opcodes 0, 2 and 3 |
| dec_valid | output | 1 | Decision present |
| dec_accept | output | 1 | Frame kept |
| dec_code | output | 3 | 0-3 slot, 4 broadcast, 5 hash, 6 promiscuous, 7 rejected |

## Verification
Every result is registered once, so the decision for a strobe driven before edge N is read after edge N and before edge N+1. The bench drives each strobe on a falling edge and samples the outputs on the next falling edge. It releases the strobe in the same step, which also checks that `dec_valid` falls back. A configuration write takes effect at the edge that captures it, so the next frame strobe already sees the new table. The same-cycle case of R11 is driven separately and its expected value uses the table from before the write.

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter #(
  parameter int SLOTS = 4,
  parameter int HBITS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frm_valid,
  input  logic [47:0] dst_addr,
  input  logic [15:0] len_type,
  input  logic [15:0] pay_len,
  input  logic        promisc_en,
  input  logic        bcast_en,
  input  logic        mcast_en,
  input  logic        lencheck_en,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_op,
  input  logic [1:0]  cfg_slot,
  input  logic [47:0] cfg_data,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic [2:0]  dec_code
);
  localparam int HSIZE = 1 << HBITS;
  localparam logic [2:0] C_BC = 3'd4, C_HASH = 3'd5, C_PROM = 3'd6, C_REJ = 3'd7;
  localparam logic [15:0] TYPE_MIN = 16'h0600;

  function automatic logic [HBITS-1:0] fold(input logic [47:0] a);
    logic [HBITS-1:0] r;
    r = '0;
    for (int k = 0; k < 48; k += HBITS) r ^= HBITS'(a >> k);
    return r;
  endfunction

  logic [47:0]      slot_a [SLOTS];
  logic [SLOTS-1:0] slot_v;
  logic [HSIZE-1:0] hash_q;
  logic [SLOTS-1:0] hit;
  logic [2:0]       code_d;

  wire is_bc    = &dst_addr;
  wire hash_hit = mcast_en && dst_addr[40] && !is_bc && hash_q[fold(dst_addr)];
  wire len_bad  = lencheck_en && (len_type < TYPE_MIN) && (len_type != pay_len);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign hit[i] = slot_v[i] && (slot_a[i] == dst_addr);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_v[i] <= 1'b0;
        slot_a[i] <= '0;
      end else if (cfg_we && cfg_slot == 2'(i)) begin
        if (cfg_op == 3'd0) begin
          slot_a[i] <= cfg_data;
          slot_v[i] <= 1'b1;
        end else if (cfg_op == 3'd1) begin
          slot_v[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hash_q <= '0;
    else if (cfg_we) begin
      case (cfg_op)
        3'd2: hash_q[fold(cfg_data)] <= 1'b1;
        3'd3: hash_q[fold(cfg_data)] <= 1'b0;
        3'd4: hash_q <= '0;
        default: ;
      endcase
    end
  end

  always_comb begin
    code_d = promisc_en ? C_PROM : C_REJ;
    if (!len_bad) begin
      if (hash_hit) code_d = C_HASH;
      if (is_bc && bcast_en) code_d = C_BC;
      for (int i = SLOTS - 1; i >= 0; i--)
        if (hit[i]) code_d = 3'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_code   <= C_REJ;
    end else begin
      dec_valid  <= frm_valid;
      dec_accept <= frm_valid && (code_d != C_REJ);
      dec_code   <= frm_valid ? code_d : C_REJ;
    end
  end
endmodule

module eth_rx_addr_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frm_valid,
  input logic [47:0] dst_addr,
  input logic        promisc_en,
  input logic        bcast_en,
  input logic        mcast_en,
  input logic        dec_valid,
  input logic        dec_accept,
  input logic [2:0]  dec_code
);
  // R1
  strobe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n) frm_valid |=> dec_valid);
  // R1
  idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n) !frm_valid |=> !dec_valid && !dec_accept);
  // R10
  acc_code_chk: assert property (@(posedge clk) disable iff (!rst_n) dec_valid |-> (dec_accept == (dec_code != 3'd7)));
  // R8
  promisc_chk: assert property (@(posedge clk) disable iff (!rst_n) frm_valid && promisc_en |=> dec_accept);
  // R4
  bc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) frm_valid && (&dst_addr) && !bcast_en |=> dec_code != 3'd4 && dec_code != 3'd5);
  // R5
  mc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) frm_valid && (!mcast_en || !dst_addr[40]) |=> dec_code != 3'd5);
endmodule

bind eth_rx_addr_filter eth_rx_addr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .dst_addr(dst_addr),
  .promisc_en(promisc_en), .bcast_en(bcast_en), .mcast_en(mcast_en),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_code(dec_code)
);

// File: tb/eth_rx_addr_filter_tb.sv
module eth_rx_addr_filter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frm_valid = 1'b0;
  logic [47:0] dst_addr = '0, cfg_data = '0;
  logic [15:0] len_type = '0, pay_len = '0;
  logic promisc_en = 0, bcast_en = 0, mcast_en = 0, lencheck_en = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_op = '0;
  logic [1:0] cfg_slot = '0;
  logic dec_valid, dec_accept;
  logic [2:0] dec_code;

  int checks = 0, errors = 0;
  logic [47:0] m_a [4];
  logic [3:0]  m_v = '0;
  logic [63:0] m_h = '0;

  always #5 clk = ~clk;

  eth_rx_addr_filter u_dut (.*);

  function automatic logic [5:0] hfold(input logic [47:0] a);
    logic [5:0] r = '0;
    for (int k = 0; k < 8; k++) r ^= a[6*k +: 6];
    return r;
  endfunction

  function automatic logic [2:0] model(input logic [47:0] da, input logic [15:0] lt, input logic [15:0] pl);
    if (lencheck_en && lt < 16'h0600 && lt != pl) return promisc_en ? 3'd6 : 3'd7;
    for (int i = 0; i < 4; i++) if (m_v[i] && m_a[i] == da) return 3'(i);
    if (&da) begin
      if (bcast_en) return 3'd4;
    end else if (da[40] && mcast_en && m_h[hfold(da)]) return 3'd5;
    return promisc_en ? 3'd6 : 3'd7;
  endfunction

  function automatic string tag(input logic [2:0] c);
    case (c)
      3'd0, 3'd1, 3'd2, 3'd3: return "R2/R3";
      3'd4: return "R4";
      3'd5: return "R5/R6";
      3'd6: return "R8";
      default: return "R9/R10";
    endcase
  endfunction

  task automatic cfg(input logic [2:0] op, input logic [1:0] s, input logic [47:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_op = op; cfg_slot = s; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
    case (op)
      3'd0: begin m_a[s] = d; m_v[s] = 1'b1; end
      3'd1: m_v[s] = 1'b0;
      3'd2: m_h[hfold(d)] = 1'b1;
      3'd3: m_h[hfold(d)] = 1'b0;
      3'd4: m_h = '0;
      default: ;
    endcase
  endtask

  task automatic judge(input logic [2:0] exp, input string t);
    checks++;
    if (!dec_valid || dec_accept != (exp != 3'd7) || dec_code != exp) begin
      errors++;
      $display("FAIL %s: valid=%0b accept=%0b code=%0d expected accept=%0b code=%0d",
               t, dec_valid, dec_accept, dec_code, exp != 3'd7, exp);
    end
  endtask

  task automatic send(input logic [47:0] da, input logic [15:0] lt, input logic [15:0] pl, input string t);
    logic [2:0] exp;
    @(negedge clk);
    exp = model(da, lt, pl);
    frm_valid = 1; dst_addr = da; len_type = lt; pay_len = pl;
    @(negedge clk);
    frm_valid = 0;
    judge(exp, (t == "") ? tag(exp) : t);
  endtask

  localparam logic [47:0] S0 = 48'h02_11_22_33_44_55, S1 = 48'h02_AA_BB_CC_DD_01,
                          S2 = 48'h00_10_20_30_40_50, S3 = 48'h02_99_88_77_66_55,
                          BC = 48'hFF_FF_FF_FF_FF_FF, M1 = 48'h01_00_5E_00_00_01,
                          M2 = 48'h33_33_00_00_00_16, M3 = 48'h01_80_C2_00_00_0E,
                          UU = 48'h00_DE_AD_BE_EF_00;

  initial begin
    logic [47:0] addrs [9];
    logic [15:0] lts [3];
    logic [15:0] pls [3];
    logic [2:0] exp;
    addrs = '{S0, S1, S2, S3, BC, M1, M2, M3, UU};
    lts = '{16'h0800, 16'd46, 16'd46};
    pls = '{16'd99, 16'd46, 16'd60};
    repeat (3) @(negedge clk);
    checks++;
    if (dec_valid || dec_accept || dec_code != 3'd7) begin
      errors++;
      $display("FAIL R1: reset valid=%0b accept=%0b code=%0d expected 0 0 7", dec_valid, dec_accept, dec_code);
    end
    rst_n = 1;
    cfg(3'd0, 2'd0, S0); cfg(3'd0, 2'd1, S1); cfg(3'd0, 2'd2, S2);
    cfg(3'd0, 2'd3, S3); cfg(3'd1, 2'd3, S3);   // R2: slot 3 invalid
    cfg(3'd2, 2'd0, M1); cfg(3'd2, 2'd0, M2);
    cfg(3'd5, 2'd0, M3); cfg(3'd7, 2'd0, M3);   // R7: unused opcodes
    for (int m = 0; m < 16; m++) begin
      {promisc_en, bcast_en, mcast_en, lencheck_en} = 4'(m);
      for (int a = 0; a < 9; a++)
        for (int l = 0; l < 3; l++) send(addrs[a], lts[l], pls[l], "");
    end
    {promisc_en, bcast_en, mcast_en, lencheck_en} = 4'b0010;
    @(negedge clk);
    checks++;
    if (dec_valid || dec_accept) begin
      errors++;
      $display("FAIL R1: idle valid=%0b accept=%0b expected 0 0", dec_valid, dec_accept);
    end
    cfg(3'd0, 2'd2, S1);
    send(S1, 16'h0800, 0, "R3 lowest slot");
    cfg(3'd0, 2'd2, S2);
    cfg(3'd3, 2'd0, M1);
    send(M1, 16'h0800, 0, "R7 delete");
    send(M2, 16'h0800, 0, "R7 delete keeps other");
    cfg(3'd4, 2'd0, '0);
    send(M2, 16'h0800, 0, "R7 clear all");
    send(M1, 16'h0800, 0, "R7 clear all");
    // R11: strobe with same-cycle write of slot 3
    @(negedge clk);
    exp = model(S3, 16'h0800, 0);
    frm_valid = 1; dst_addr = S3; len_type = 16'h0800;
    cfg_we = 1; cfg_op = 3'd0; cfg_slot = 2'd3; cfg_data = S3;
    @(negedge clk);
    frm_valid = 0; cfg_we = 0; m_a[3] = S3; m_v[3] = 1'b1;
    judge(exp, "R11 old table");
    send(S3, 16'h0800, 0, "R11 new table");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL R1: watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule